// File: doc/BRIEF.md
# Two-Wire Serial Shift Unit

This block is the physical-layer shifter for an I2C-compatible two-wire link. It works on either side of the link. An 8-bit data register shifts out on SDA with the MSB first and takes in one bit for every SCL clock pulse. A 4-bit counter advances on every SCL transition and raises a completion flag when it wraps. Both bus lines are open-drain. Each is modelled by a pull-down enable output and a line-level input. The block has no slew-rate limiting and no input filtering, so each line input is used exactly as it arrives.

In master mode, software produces the clock by toggling a port bit. That bit directly pulls SCL low or releases it. The counter follows the real line level, so a clock stretched by the far end is not counted until the line actually rises. In slave mode, SCL comes from outside. The block can stretch the clock by holding SCL low on a hold request, or after a counter overflow until software clears the flag. Protocol sequencing, addressing and start/stop decoding are left to software.

Top module: `twi_shift_unit`

## Requirements
- R1: The data register shifts left only on a falling SCL edge (SCL input sampled 1 on the previous clock and 0 now). The bit taken into the LSB is the SDA input level latched at the most recent rising SCL edge. Neither a rising edge nor a steady SCL level changes the data register.
- R2: Each SCL transition in either direction advances the counter by one. A transition seen while the counter holds 15 wraps it to 0 and sets the overflow flag. One byte therefore completes after 16 transitions from a count of 0.
- R3: A counter clear or counter preload in the same clock as an SCL transition takes priority over the increment. A data load in the same clock as a falling edge takes priority over the shift. Preloading 14 makes the flag set after exactly two transitions.
- R4: The overflow flag stays set until a 1 is written on the flag-clear input. If an overflow happens in the same clock as the clear, the flag stays set.
- R5: In master mode, scl_oe is the inverse of the port bit (port 0 pulls the line low). Hold requests and hold-on-overflow have no effect on SCL.
- R6: In slave mode, scl_oe is 1 while the hold request is asserted, or while hold-on-overflow is enabled and the overflow flag is set. Otherwise scl_oe is 0.
- R7: While SDA drive is enabled, sda_oe is the inverse of data bit 7, so the byte appears on the line MSB first. With drive disabled, sda_oe is 0.
- R8: Counting follows the sampled line and not the port bit. When a master releases SCL but the line is held low from outside, the counter does not advance until the line reads high.
- R9: After reset, the data register is 0x00, the counter is 0, the overflow flag is 0, and both lines are released (scl_oe and sda_oe are 0 in slave mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 selects master, 0 selects slave |
| scl_port | input | 1 | Software SCL port bit (master only) |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | SCL pull-down enable |
| sda_oe | output | 1 | SDA pull-down enable |
| sda_en | input | 1 | Allow the data register to drive SDA |
| hold_req | input | 1 | Slave request to hold SCL low |
| hold_on_ovf | input | 1 | Slave holds SCL low while the overflow flag is set |
| cnt_clr | input | 1 | Clear the edge counter |
| cnt_load | input | 1 | Load the edge counter |
| cnt_load_val | input | 4 | Value for the counter load |
| data_load | input | 1 | Load the data register |
| data_load_val | input | 8 | Value for the data load |
| ovf_clr | input | 1 | Write 1 to clear the overflow flag |
| data_q | output | 8 | Data register |
| cnt_q | output | 4 | Edge counter |
| ovf_flag | output | 1 | Transfer-complete (overflow) flag |

## Verification
A corrupted data register shows up on sda_oe at the next high phase of SCL, and in the received byte once eight bits have arrived. A miscounting edge counter shows up as an overflow flag that comes one or more transitions early or late. In slave mode with hold-on-overflow enabled, the same fault also shows up as SCL being pulled low at the wrong time. A wrong edge history register makes a shift happen on the wrong polarity, and every byte in the sweep then comes out scrambled.

// File: rtl/twi_shift_unit.sv
module twi_shift_unit #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          scl_port,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_en,
  input  logic          hold_req,
  input  logic          hold_on_ovf,
  input  logic          cnt_clr,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_load_val,
  input  logic          data_load,
  input  logic [DW-1:0] data_load_val,
  input  logic          ovf_clr,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_flag
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic scl_q;
  logic sda_smp;
  logic scl_rise, scl_fall, scl_edge, wrap;

  assign scl_rise = scl_in & ~scl_q;
  assign scl_fall = ~scl_in & scl_q;
  assign scl_edge = scl_rise | scl_fall;
  assign wrap     = scl_edge & (cnt_q == CNT_TOP) & ~cnt_clr & ~cnt_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_smp <= 1'b1;
    end else begin
      scl_q <= scl_in;
      if (scl_rise) sda_smp <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (data_load) data_q <= data_load_val;
    else if (scl_fall)  data_q <= {data_q[DW-2:0], sda_smp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (cnt_clr)  cnt_q <= '0;
    else if (cnt_load) cnt_q <= cnt_load_val;
    else if (scl_edge) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (wrap)    ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign scl_oe = master_mode ? ~scl_port : (hold_req | (hold_on_ovf & ovf_flag));
  assign sda_oe = sda_en & ~data_q[DW-1];
endmodule

module twi_shift_unit_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_mode,
  input logic          scl_port,
  input logic          scl_in,
  input logic          scl_q,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          sda_en,
  input logic          hold_req,
  input logic          hold_on_ovf,
  input logic          cnt_clr,
  input logic          cnt_load,
  input logic          data_load,
  input logic          ovf_clr,
  input logic [DW-1:0] data_q,
  input logic [CW-1:0] cnt_q,
  input logic          ovf_flag
);
  logic edge_now;
  assign edge_now = scl_in ^ scl_q;

  p_no_shift_without_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_load && !(scl_q && !scl_in)) |=> $stable(data_q));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && !cnt_clr && !cnt_load) |=> cnt_q == CW'($past(cnt_q) + 1'b1));

  p_wrap_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_now && !cnt_clr && !cnt_load && cnt_q == {CW{1'b1}}) |=> ovf_flag);

  p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_q == '0);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_master_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && scl_port) |-> !scl_oe);

  p_slave_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (hold_req || (hold_on_ovf && ovf_flag))) |-> scl_oe);

  p_sda_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_en |-> !sda_oe);
endmodule

bind twi_shift_unit twi_shift_unit_chk #(.DW(DW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .scl_port(scl_port),
  .scl_in(scl_in), .scl_q(scl_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .sda_en(sda_en), .hold_req(hold_req), .hold_on_ovf(hold_on_ovf),
  .cnt_clr(cnt_clr), .cnt_load(cnt_load), .data_load(data_load),
  .ovf_clr(ovf_clr), .data_q(data_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag)
);

// File: tb/twi_shift_unit_tb_top.sv
module twi_shift_unit_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       master_mode = 1'b0, scl_port = 1'b1, scl_drv = 1'b1, stretch = 1'b0;
  logic       sda_in = 1'b1, sda_en = 1'b0, hold_req = 1'b0, hold_on_ovf = 1'b0;
  logic       cnt_clr = 1'b0, cnt_load = 1'b0, data_load = 1'b0, ovf_clr = 1'b0;
  logic [3:0] cnt_load_val = '0;
  logic [7:0] data_load_val = '0;
  logic       scl_in, scl_oe, sda_oe, ovf_flag;
  logic [7:0] data_q;
  logic [3:0] cnt_q;

  assign scl_in = master_mode ? (~scl_oe & ~stretch) : scl_drv;

  twi_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .scl_port(scl_port),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_en(sda_en), .hold_req(hold_req), .hold_on_ovf(hold_on_ovf),
    .cnt_clr(cnt_clr), .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .data_load(data_load), .data_load_val(data_load_val), .ovf_clr(ovf_clr),
    .data_q(data_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_scl(input logic v);
    @(negedge clk) scl_drv = v;
    step(2);
  endtask

  task automatic prep(input logic [7:0] d);
    @(negedge clk);
    data_load = 1'b1; data_load_val = d; cnt_clr = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    data_load = 1'b0; cnt_clr = 1'b0; ovf_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R9 data", data_q, 0);
    chk("R9 cnt", cnt_q, 0);
    chk("R9 ovf", ovf_flag, 0);
    chk("R9 scl_oe", scl_oe, 0);
    chk("R9 sda_oe", sda_oe, 0);
    @(negedge clk) rst_n = 1'b1;
    sda_en = 1'b1;
    set_scl(1'b0);

    // R1 R2 R7: full byte sweep in slave mode
    for (int b = 0; b < 256; b++) begin
      logic [7:0] tx, rx;
      tx = 8'(b);
      rx = 8'((b * 37 + 11) & 255);
      prep(tx);
      for (int i = 7; i >= 0; i--) begin
        chk("R7 sda bit", sda_oe, int'(!tx[i]));
        sda_in = rx[i];
        set_scl(1'b1);
        if (i == 0) begin
          chk("R2 cnt before wrap", cnt_q, 15);
          chk("R2 no early ovf", ovf_flag, 0);
          chk("R1 no shift on rise", data_q, int'({tx[0], rx[7:1]}));
        end
        set_scl(1'b0);
      end
      chk("R1 received byte", data_q, rx);
      chk("R2 ovf after 16 edges", ovf_flag, 1);
      chk("R2 cnt wrapped", cnt_q, 0);
    end

    // R3: preload 14 overflows after two edges
    prep(8'h00);
    @(negedge clk) begin cnt_load = 1'b1; cnt_load_val = 4'd14; end
    @(negedge clk) cnt_load = 1'b0;
    set_scl(1'b1);
    chk("R3 preload cnt", cnt_q, 15);
    chk("R3 preload no ovf", ovf_flag, 0);
    set_scl(1'b0);
    chk("R3 preload ovf", ovf_flag, 1);

    // R3: clear beats edge, data load beats shift
    prep(8'hA5);
    @(negedge clk) begin scl_drv = 1'b1; cnt_clr = 1'b1; end
    @(negedge clk) cnt_clr = 1'b0;
    chk("R3 clear over edge", cnt_q, 0);
    step(1);
    @(negedge clk) begin scl_drv = 1'b0; data_load = 1'b1; data_load_val = 8'h3C; end
    @(negedge clk) data_load = 1'b0;
    chk("R3 load over shift", data_q, 8'h3C);
    chk("R3 edge counted", cnt_q, 1);

    // R4: set wins over clear, then clear works
    prep(8'h00);
    @(negedge clk) begin cnt_load = 1'b1; cnt_load_val = 4'd15; end
    @(negedge clk) begin cnt_load = 1'b0; scl_drv = 1'b1; ovf_clr = 1'b1; end
    @(negedge clk) ovf_clr = 1'b0;
    chk("R4 set wins", ovf_flag, 1);
    step(3);
    chk("R4 sticky", ovf_flag, 1);

    // R6: slave holds
    chk("R6 no hold", scl_oe, 0);
    hold_on_ovf = 1'b1; #1;
    chk("R6 hold on ovf", scl_oe, 1);
    @(negedge clk) ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk("R4 cleared", ovf_flag, 0);
    chk("R6 released after clear", scl_oe, 0);
    hold_req = 1'b1; #1;
    chk("R6 hold request", scl_oe, 1);
    hold_req = 1'b0; #1;
    chk("R6 hold request off", scl_oe, 0);

    // R5: master ignores holds
    @(negedge clk) begin cnt_load = 1'b1; cnt_load_val = 4'd15; end
    @(negedge clk) begin cnt_load = 1'b0; scl_drv = 1'b0; end
    step(2);
    hold_req = 1'b1;
    chk("R5 ovf set for test", ovf_flag, 1);
    @(negedge clk) begin master_mode = 1'b1; scl_port = 1'b1; end
    step(2);
    chk("R5 port 1 releases", scl_oe, 0);
    @(negedge clk) scl_port = 1'b0;
    step(2);
    chk("R5 port 0 pulls", scl_oe, 1);
    hold_req = 1'b0; hold_on_ovf = 1'b0;

    // R8: stretched master clock not counted until line rises
    @(negedge clk) cnt_clr = 1'b1;
    @(negedge clk) cnt_clr = 1'b0;
    @(negedge clk) begin stretch = 1'b1; scl_port = 1'b1; end
    step(5);
    chk("R8 line still low", scl_in, 0);
    chk("R8 no count while stretched", cnt_q, 0);
    @(negedge clk) stretch = 1'b0;
    step(2);
    chk("R8 counted on release", cnt_q, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule